// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Window

This block sits between an 8-bit host memory bus and a 16-bit ATA drive. It claims a 16-byte window of host memory space. Each read or write strobe inside that window becomes a programmed-I/O cycle on the drive's task-file registers. The register index comes from address bits [3:1], so consecutive registers sit two bytes apart and software can reach them with ordinary memory moves. The status register sits at offset 0xE and is polled with a byte read: bit 7 is busy and bit 3 is data request.

The drive data register is 16 bits wide, and a pair of byte latches carries it over the 8-bit host bus. On a read, a drive cycle returns the low byte to the host and parks the high byte in the block. The next data-register read then gets that byte without touching the drive. On a write, the first byte is parked in the block. Only the second byte starts a drive write, which presents both bytes together. Every drive cycle has one clock of address setup, a read or write strobe held low for a parameterised number of clocks, and one clock of hold.

The host raises `host_rd` or `host_wr` for one clock and waits for the one-clock `host_ack`. Accesses outside the window are left alone so that other decoders can answer them.

Top module: `ata_mem_window`

## Requirements
- R1: While and directly after reset, ata_cs0_n, ata_cs1_n, ata_dior_n and ata_diow_n are high, and host_ack and ata_doe are low.
- R2: A request whose address bits above bit 3 differ from the window base gets no acknowledge, no drive strobe and no change to either byte latch.
- R3: During a drive cycle, ata_da equals request address bits [3:1]. For example, offset 0x4 gives 2, offset 0xC gives 6 and offset 0xE gives 7. ata_cs0_n is low while a strobe is low, and ata_cs1_n is never driven low.
- R4: Each drive strobe stays low for exactly PULSE_CYC clocks. ata_cs0_n and ata_da are settled one clock before the strobe falls and stay unchanged for one clock after it rises. A drive access is acknowledged PULSE_CYC+2 clocks after the request clock.
- R5: A read of any register other than the data register (index 1 to 7) runs one read strobe and returns ata_din[7:0] on host_rdata with the acknowledge.
- R6: A write to any register other than the data register runs one write strobe. During that strobe, ata_dout is {8'h00, host byte} and ata_doe is high.
- R7: A data-register read (index 0) with no high byte parked runs one read strobe. It returns ata_din[7:0] and parks ata_din[15:8].
- R8: A data-register read while a high byte is parked runs no strobe. It returns the parked byte, is acknowledged one clock after the request, and leaves no byte parked.
- R9: A data-register write with no low byte held runs no strobe. It holds the host byte and is acknowledged one clock after the request.
- R10: A data-register write while a low byte is held runs one write strobe. It drives ata_dout = {new byte, held byte} and leaves no byte held.
- R11: The read latch and the write latch are independent. Neither is changed by accesses to other registers or by data accesses in the opposite direction.
- R12: host_ack is high for exactly one clock per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host memory address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | One-clock memory read request |
| host_wr | input | 1 | One-clock memory write request |
| host_rdata | output | 8 | Read byte, valid with host_ack on reads |
| host_ack | output | 1 | One-clock completion pulse |
| ata_cs0_n | output | 1 | Task-file chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, held high |
| ata_da | output | 3 | Drive register address |
| ata_dior_n | output | 1 | Drive read strobe, active low |
| ata_diow_n | output | 1 | Drive write strobe, active low |
| ata_dout | output | 16 | Data driven to the drive |
| ata_doe | output | 1 | Enable for ata_dout onto the drive bus |
| ata_din | input | 16 | Data returned by the drive |

## Verification
The assertions take for granted that the host raises at most one of host_rd and host_wr in a clock. They also assume that no new request arrives between a request and its acknowledge; an overlapping request would be dropped, and the timing checks on setup, hold and pulse width would not describe it. The bench respects both limits by issuing each request for a single clock and waiting for host_ack, or for a timeout on accesses outside the window, before it starts the next one. It holds ata_din constant across each access, so the byte the block samples at the end of the strobe is the byte the bench expects.

// File: rtl/ata_win_pkg.sv
package ata_win_pkg;

    localparam int OFS_W   = 4;
    localparam int IDX_W   = 3;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam logic [IDX_W-1:0] IDX_DATA = '0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_PULSE,
        SQ_RECOV,
        SQ_QUICK
    } seq_state_e;

    typedef enum logic [1:0] {
        RT_NONE,
        RT_QUICK,
        RT_DRIVE
    } route_e;

    typedef struct packed {
        logic              wr;
        logic              data;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } drive_op_t;

    function automatic logic [IDX_W-1:0] reg_index(input logic [OFS_W-1:0] ofs);
        return ofs[OFS_W-1:1];
    endfunction

endpackage

// File: rtl/ata_win_latch.sv
module ata_win_latch
    import ata_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_hi,
    input  logic              fetch_hi,
    input  logic [BYTE_W-1:0] fetch_byte,
    input  logic              store_lo,
    input  logic [BYTE_W-1:0] store_byte,
    input  logic              flush_lo,
    output logic              rd_pend,
    output logic [BYTE_W-1:0] rd_hi,
    output logic              wr_held,
    output logic [BYTE_W-1:0] wr_lo
);

    // Read side: high byte of a drive word parked for the host.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            rd_hi   <= '0;
        end else if (fetch_hi) begin
            rd_pend <= 1'b1;
            rd_hi   <= fetch_byte;
        end else if (take_hi) begin
            rd_pend <= 1'b0;
        end
    end

    // Write side: low byte of a word waiting for its partner.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_held <= 1'b0;
            wr_lo   <= '0;
        end else if (store_lo) begin
            wr_held <= 1'b1;
            wr_lo   <= store_byte;
        end else if (flush_lo) begin
            wr_held <= 1'b0;
        end
    end

endmodule

// File: rtl/ata_win_decode.sv
module ata_win_decode
    import ata_win_pkg::*;
#(
    parameter int                 ADDR_W   = 20,
    parameter logic [ADDR_W-1:0]  WIN_BASE = 20'hC8000
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              idle,
    input  logic              rd_pend,
    input  logic              wr_held,
    input  logic [BYTE_W-1:0] wr_lo,
    output route_e            route,
    output drive_op_t         op,
    output logic              take_hi,
    output logic              store_lo
);

    localparam int TAG_W = ADDR_W - OFS_W;

    logic             hit;
    logic             req;
    logic [IDX_W-1:0] idx;
    logic             is_data;

    assign hit     = host_addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W];
    assign req     = idle && hit && (host_rd || host_wr);
    assign idx     = reg_index(host_addr[OFS_W-1:0]);
    assign is_data = idx == IDX_DATA;

    always_comb begin
        op.wr   = host_wr;
        op.data = is_data;
        op.idx  = idx;
        op.word = (is_data && host_wr) ? {host_wdata, wr_lo}
                                       : {{BYTE_W{1'b0}}, host_wdata};
        route    = RT_NONE;
        take_hi  = 1'b0;
        store_lo = 1'b0;
        if (req) begin
            if (is_data && !host_wr && rd_pend) begin
                route   = RT_QUICK;
                take_hi = 1'b1;
            end else if (is_data && host_wr && !wr_held) begin
                route    = RT_QUICK;
                store_lo = 1'b1;
            end else begin
                route = RT_DRIVE;
            end
        end
    end

    if (TAG_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed the window offset width");
    end

endmodule

// File: rtl/ata_win_seq.sv
module ata_win_seq
    import ata_win_pkg::*;
#(
    parameter int PULSE_CYC = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_drive,
    input  logic              go_quick,
    input  drive_op_t         op_in,
    output logic              idle,
    output logic              pulse_end,
    output logic              ack,
    output logic              cur_wr,
    output logic              cur_data,
    output logic              cs0_n,
    output logic [IDX_W-1:0]  da,
    output logic              dior_n,
    output logic              diow_n,
    output logic [WORD_W-1:0] dout,
    output logic              doe
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    drive_op_t        cur;
    logic             in_cycle;

    assign pulse_end = (state == SQ_PULSE) && (cnt == CNT_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:  if (go_drive) state_nx = SQ_SETUP;
                      else if (go_quick) state_nx = SQ_QUICK;
            SQ_SETUP: state_nx = SQ_PULSE;
            SQ_PULSE: if (pulse_end) state_nx = SQ_RECOV;
            SQ_RECOV: state_nx = SQ_IDLE;
            SQ_QUICK: state_nx = SQ_IDLE;
            default:  state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            state <= state_nx;
            if (state == SQ_PULSE) cnt <= cnt + 1'b1;
            else                   cnt <= '0;
            if (state == SQ_IDLE && go_drive) cur <= op_in;
        end
    end

    assign in_cycle = (state == SQ_SETUP) || (state == SQ_PULSE) || (state == SQ_RECOV);
    assign idle     = state == SQ_IDLE;
    assign ack      = (state == SQ_RECOV) || (state == SQ_QUICK);
    assign cur_wr   = cur.wr;
    assign cur_data = cur.data;
    assign cs0_n    = !in_cycle;
    assign da       = in_cycle ? cur.idx : '0;
    assign dior_n   = !((state == SQ_PULSE) && !cur.wr);
    assign diow_n   = !((state == SQ_PULSE) && cur.wr);
    assign doe      = in_cycle && cur.wr;
    assign dout     = cur.word;

endmodule

// File: rtl/ata_mem_window.sv
module ata_mem_window
    import ata_win_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC8000,
    parameter int                PULSE_CYC = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [7:0]        host_rdata,
    output logic              host_ack,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic [15:0]       ata_dout,
    output logic              ata_doe,
    input  logic [15:0]       ata_din
);

    route_e            route;
    drive_op_t         op;
    logic              take_hi, store_lo;
    logic              idle, pulse_end, cur_wr, cur_data;
    logic              rd_pend, wr_held;
    logic [BYTE_W-1:0] rd_hi, wr_lo;
    logic              fetch_hi, flush_lo;

    ata_win_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .idle       (idle),
        .rd_pend    (rd_pend),
        .wr_held    (wr_held),
        .wr_lo      (wr_lo),
        .route      (route),
        .op         (op),
        .take_hi    (take_hi),
        .store_lo   (store_lo)
    );

    ata_win_seq #(
        .PULSE_CYC (PULSE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_drive  (route == RT_DRIVE),
        .go_quick  (route == RT_QUICK),
        .op_in     (op),
        .idle      (idle),
        .pulse_end (pulse_end),
        .ack       (host_ack),
        .cur_wr    (cur_wr),
        .cur_data  (cur_data),
        .cs0_n     (ata_cs0_n),
        .da        (ata_da),
        .dior_n    (ata_dior_n),
        .diow_n    (ata_diow_n),
        .dout      (ata_dout),
        .doe       (ata_doe)
    );

    assign fetch_hi = pulse_end && !cur_wr && cur_data;
    assign flush_lo = pulse_end && cur_wr && cur_data;

    ata_win_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .take_hi    (take_hi),
        .fetch_hi   (fetch_hi),
        .fetch_byte (ata_din[WORD_W-1:BYTE_W]),
        .store_lo   (store_lo),
        .store_byte (host_wdata),
        .flush_lo   (flush_lo),
        .rd_pend    (rd_pend),
        .rd_hi      (rd_hi),
        .wr_held    (wr_held),
        .wr_lo      (wr_lo)
    );

    // Host read byte: parked high byte on a latch hit, drive low byte at strobe end.
    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (take_hi) begin
            host_rdata <= rd_hi;
        end else if (pulse_end && !cur_wr) begin
            host_rdata <= ata_din[BYTE_W-1:0];
        end
    end

    assign ata_cs1_n = 1'b1;

endmodule

// File: rtl/ata_mem_window_chk.sv
module ata_mem_window_chk #(
    parameter int PULSE_CYC = 17
) (
    input logic       clk,
    input logic       rst,
    input logic       host_ack,
    input logic       ata_cs0_n,
    input logic       ata_cs1_n,
    input logic [2:0] ata_da,
    input logic       ata_dior_n,
    input logic       ata_diow_n,
    input logic       ata_doe
);

    logic [31:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)                           low_cnt <= '0;
        else if (!ata_dior_n || !ata_diow_n) low_cnt <= low_cnt + 1'b1;
        else                               low_cnt <= '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !host_ack && !ata_doe));

    assert_strobe_in_select_R3: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n && ata_cs1_n));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(!ata_dior_n && !ata_diow_n));

    assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ata_dior_n) || $fell(ata_diow_n)) |-> ($past(!ata_cs0_n) && $stable(ata_da)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(ata_dior_n) || $rose(ata_diow_n)) |-> (!ata_cs0_n && $stable(ata_da)));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(ata_dior_n) || $rose(ata_diow_n)) |-> (low_cnt == 32'(PULSE_CYC)));

    assert_doe_write_only_R6: assert property (@(posedge clk) disable iff (rst)
        ata_doe |-> (ata_dior_n && !ata_cs0_n));

    assert_ack_single_R12: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

endmodule

bind ata_mem_window ata_mem_window_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ack   (host_ack),
    .ata_cs0_n  (ata_cs0_n),
    .ata_cs1_n  (ata_cs1_n),
    .ata_da     (ata_da),
    .ata_dior_n (ata_dior_n),
    .ata_diow_n (ata_diow_n),
    .ata_doe    (ata_doe)
);

// File: tb/test_ata_mem_window.sv
module test_ata_mem_window;

    localparam int          PULSE = 9;
    localparam logic [19:0] BASE  = 20'hC8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_doe;
    logic [2:0]  ata_da;
    logic [15:0] ata_dout;
    logic [15:0] ata_din = '0;

    always #5 clk = ~clk;

    ata_mem_window #(.ADDR_W(20), .WIN_BASE(BASE), .PULSE_CYC(PULSE)) i_ata_mem_window (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata), .host_ack(host_ack),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dout(ata_dout),
        .ata_doe(ata_doe), .ata_din(ata_din)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Drive-side monitor, sampled on falling edges.
    int          rd_pulses, wr_pulses, rd_low, wr_low, setup_bad, hold_bad, cs1_seen;
    logic [15:0] seen_dout;
    logic [2:0]  seen_da;
    logic        seen_doe;
    logic        p_dior_n = 1, p_diow_n = 1, p_cs0_n = 1;
    logic [2:0]  p_da = '0;

    always @(negedge clk) begin
        if (!ata_dior_n) begin
            rd_low++;
            if (p_dior_n) begin
                rd_pulses++;
                if (p_cs0_n || p_da != ata_da) setup_bad++;
            end
            seen_da = ata_da;
        end else if (!p_dior_n && (ata_cs0_n || p_da != ata_da)) hold_bad++;
        if (!ata_diow_n) begin
            wr_low++;
            if (p_diow_n) begin
                wr_pulses++;
                if (p_cs0_n || p_da != ata_da) setup_bad++;
            end
            seen_da = ata_da; seen_dout = ata_dout; seen_doe = ata_doe;
        end else if (!p_diow_n && (ata_cs0_n || p_da != ata_da)) hold_bad++;
        if (!ata_cs1_n) cs1_seen++;
        p_dior_n = ata_dior_n; p_diow_n = ata_diow_n; p_cs0_n = ata_cs0_n; p_da = ata_da;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench model of the two byte latches.
    bit         m_pend = 0, m_held = 0;
    logic [7:0] m_hi = 0, m_lo = 0;

    task automatic access(input bit wr, input logic [19:0] addr, input logic [7:0] wd,
                          output logic [7:0] rdv, output int lat, output bit ack_twice);
        rd_pulses = 0; wr_pulses = 0; rd_low = 0; wr_low = 0;
        setup_bad = 0; hold_bad = 0; seen_doe = 0; seen_dout = 'x; seen_da = 'x;
        host_addr = addr; host_wdata = wd; host_rd = !wr; host_wr = wr;
        @(negedge clk);
        host_rd = 0; host_wr = 0;
        lat = 1;
        while (!host_ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (!host_ack) lat = 0;
        rdv = host_rdata;
        @(negedge clk);
        ack_twice = host_ack;
        @(negedge clk);
    endtask

    // One access checked against the model.
    task automatic run(input bit wr, input logic [19:0] addr, input logic [7:0] wd,
                       input logic [15:0] din, input string tagx);
        logic [7:0] rdv;
        int lat;
        bit twice;
        bit in_win, is_data, quick;
        logic [2:0] idx;
        logic [7:0] exp_rd;
        logic [15:0] exp_word;
        string tag;
        in_win  = addr[19:4] == BASE[19:4];
        idx     = addr[3:1];
        is_data = idx == 3'd0;
        quick   = in_win && is_data && (wr ? !m_held : m_pend);
        exp_rd  = 'x; exp_word = 'x;
        if (!in_win) tag = "R2";
        else if (is_data && !wr) tag = quick ? "R8" : "R7";
        else if (is_data && wr)  tag = quick ? "R9" : "R10";
        else tag = wr ? "R6" : "R5";
        if (tagx != "") tag = {tag, "/", tagx};
        if (in_win) begin
            if (!wr) begin
                if (quick) begin exp_rd = m_hi; m_pend = 0; end
                else begin
                    exp_rd = din[7:0];
                    if (is_data) begin m_hi = din[15:8]; m_pend = 1; end
                end
            end else begin
                if (quick) begin m_lo = wd; m_held = 1; end
                else begin
                    exp_word = is_data ? {wd, m_lo} : {8'h00, wd};
                    if (is_data) m_held = 0;
                end
            end
        end
        ata_din = din;
        access(wr, addr, wd, rdv, lat, twice);
        if (!in_win) begin
            chk({tag, " no ack"}, lat, 0);
            chk({tag, " no strobe"}, rd_pulses + wr_pulses, 0);
        end else begin
            chk({tag, " latency"}, lat, quick ? 1 : PULSE + 2);
            chk({tag, " R12 single ack"}, int'(twice), 0);
            chk({tag, " read strobes"}, rd_pulses, (!quick && !wr) ? 1 : 0);
            chk({tag, " write strobes"}, wr_pulses, (!quick && wr) ? 1 : 0);
            if (!wr) chk({tag, " read data"}, int'(rdv), int'(exp_rd));
            if (!quick) begin
                chk({tag, " R3 da"}, int'(seen_da), int'(idx));
                chk({tag, " R4 width"}, rd_low + wr_low, PULSE);
                chk({tag, " R4 setup/hold"}, setup_bad + hold_bad, 0);
                if (wr) begin
                    chk({tag, " write word"}, int'(seen_dout), int'(exp_word));
                    chk({tag, " doe"}, int'(seen_doe), 1);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4721));
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset and just after it
        chk("R1 cs0_n", int'(ata_cs0_n), 1);
        chk("R1 dior_n", int'(ata_dior_n), 1);
        chk("R1 diow_n", int'(ata_diow_n), 1);
        chk("R1 ack", int'(host_ack), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset doe", int'(ata_doe), 0);
        chk("R1 after reset cs1_n", int'(ata_cs1_n), 1);

        // Task registers: R3 index mapping, R5/R6
        run(1, BASE + 20'h4, 8'h3F, 16'h0, "R3");
        run(1, BASE + 20'hC, 8'hA0, 16'h0, "R3");
        run(1, BASE + 20'hE, 8'h20, 16'h0, "R3");
        run(0, BASE + 20'hE, 8'h00, 16'h5A88, "R3");
        run(0, BASE + 20'h2, 8'h00, 16'h1201, "");
        // Data read pair: R7 then R8
        run(0, BASE, 8'h00, 16'hBEEF, "");
        run(0, BASE, 8'h00, 16'h0000, "");
        // Data write pair: R9 then R10
        run(1, BASE, 8'h11, 16'h0, "");
        run(1, BASE, 8'h22, 16'h0, "");
        // R11: parked bytes survive other accesses
        run(0, BASE, 8'h00, 16'hC3D4, "R11");
        run(1, BASE + 20'h6, 8'h01, 16'h0, "R11");
        run(1, BASE, 8'h77, 16'h0, "R11");
        run(0, BASE + 20'hE, 8'h00, 16'h0058, "R11");
        run(0, BASE, 8'h00, 16'hFFFF, "R11");
        run(1, BASE, 8'h99, 16'h0, "R11");
        // R2: outside the window leaves the latches alone
        run(1, BASE + 20'h10, 8'hEE, 16'h0, "");
        run(0, BASE - 20'h10, 8'h00, 16'h1234, "");
        run(1, BASE, 8'h55, 16'h0, "R2");
        run(1, BASE, 8'h66, 16'h0, "R2");

        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            if (($urandom % 8) == 0) a = BASE ^ (20'h10 << ($urandom % 16));
            else a = BASE + 20'($urandom % 16);
            run($urandom % 2, a, 8'($urandom), 16'($urandom), "rand");
        end
        chk("R3 cs1 never low", cs1_seen, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule